// File: doc/BRIEF.md
# Single-Instruction Byte Transport Processor

This block is an 8-bit processor core that knows exactly one operation: copy a byte from one place to another. Each cycle it fetches a 13-bit word from an instruction ROM addressed by a 16-bit program counter. The word names a destination port and either a source port or an 8-bit literal. The chosen source drives a single shared byte bus and the chosen destination captures it on the same clock edge. Arithmetic, logic, stack handling, branching and output all happen because a value was written to a particular port or read from one. There is no opcode decoder steering a control path.

A program loads two operand latches and then reads result ports such as sum, difference, bitwise, shift and compare results. It builds a 16-bit jump by loading a high-byte latch first and then writing the low byte to one of the jump ports. It makes a subroutine call by pushing the return-address ports onto the hardware stack before jumping. It returns by popping those bytes back into the jump ports. Stack misuse raises a sticky error flag that software can read and clear.

Top module: `tmove_core`

## Requirements
- R1: The instruction word carries three fields: bit 0 is a literal flag, bits 4..1 are the destination code and bits 12..5 are the source code. When the literal flag is 1, bits 12..5 themselves go on the bus.
- R2: Every instruction completes in one clock. Without a taken jump, `instr_addr` advances by one per cycle, wrapping at 16 bits. Reset puts `instr_addr` at 0, clears both general registers, both operand latches, the high-byte latch, the stack and the error flag, and holds `out_port` and `out_strobe` at 0.
- R3: The destination codes are 1 for general register G0, 2 for G1, 3 for operand latch A and 4 for operand latch B. Only the addressed destination changes. Codes 0 and 15 change nothing.
- R4: The arithmetic sources are 4 for A+B modulo 256, 5 for the carry of A+B (0 or 1), 6 for A-B modulo 256, 7 for A<B unsigned (0 or 1), 14 for A+1 and 15 for A-1. Sources 0 to 3 read G0, G1, A and B.
- R5: The logic sources are 8 for A AND B, 9 for OR, 10 for XOR, 11 for NOT A, 12 for A shifted left, 13 for A shifted right with a zero fill, and 24 to 31 for the single-bit mask 1<<(code-24). Further sources are 32 for A==B, 33 for signed A<B, 34 for A==0, 35 for A with its nibbles swapped, 36 for A rotated left, 37 for A rotated right, 38 for an arithmetic right shift of A, 39 for the count of ones in A and 40 for the constant 0xFF.
- R6: Any source code from 41 to 255, read without the literal flag, puts 0x00 on the bus.
- R7: Destination 5 stores the bus byte in a high-byte latch, which keeps its value until written again. Destination 6 makes the next `instr_addr` equal {latch, bus}. Source 23 reads the latch back.
- R8: Destination 7 jumps to {latch, bus} only when G0 is 0. Destination 8 jumps only when G0 is not 0. Destination 12 jumps only when A+B produces a carry. Otherwise execution falls through to the next address.
- R9: Source 20 reads the low byte and source 21 reads the high byte of the current instruction address plus one.
- R10: The stack is last-in first-out. Destination 9 pushes the bus byte, source 16 pops and returns the top, and source 17 reads the top without popping (0 when empty). Source 18 gives the entry count and destination 13 discards the top. Destination 14 empties the stack. A pop source combined with a push destination replaces the top.
- R11: A push to a full stack, or a pop or discard on an empty stack, leaves the count unchanged and sets a sticky error flag. A failed pop reads 0x00. The flag appears on `stack_err` and as source 19. Destination 11 clears it.
- R12: Destination 10 copies the bus byte to `out_port` one clock later and raises `out_strobe` for that single cycle. At all other times `out_port` holds its value.
- R13: Source 22 reads `in_port` as it stands at the executing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_addr | output | 16 | Program counter, addresses the instruction ROM |
| instr_word | input | 13 | Instruction at `instr_addr`, combinational from ROM |
| in_port | input | 8 | External byte readable as a source |
| out_port | output | 8 | Last byte written to the output destination |
| out_strobe | output | 1 | High for one cycle after an output write |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench goes after the stack edges: nine pushes into eight slots, a pop past empty, a discard on empty, and a pop and push in the same move. A design with an off-by-one limit would let the count reach 9 or wrap to 15. A design that did not make the flag sticky would lose the error before software reads it. Jumps are checked with the condition both true and false. A core that ignored the condition, or that combined a stale high byte with the target, would execute the byte-output instruction placed in the skipped slot. Unimplemented source codes, together with the destination codes 0 and 15, are checked so that a decoder that aliased them onto real ports would be caught writing G0 or leaking nonzero data.

// File: rtl/tmv_pkg.sv
package tmv_pkg;
  localparam int DATA_W   = 8;
  localparam int PC_W     = 16;
  localparam int DST_W    = 4;
  localparam int SRC_W    = 8;
  localparam int INSTR_W  = 1 + DST_W + SRC_W;
  localparam int NUM_DST  = 1 << DST_W;
  localparam int DST_USED = 15;
  localparam int HALF_W   = DATA_W / 2;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DST_W-1:0] dst;
    logic             imm;
  } move_t;

  // destination codes
  localparam logic [DST_W-1:0] D_NULL = 4'd0,  D_R0   = 4'd1,  D_R1   = 4'd2,
                               D_OPA  = 4'd3,  D_OPB  = 4'd4,  D_JHI  = 4'd5,
                               D_JMP  = 4'd6,  D_JZ   = 4'd7,  D_JNZ  = 4'd8,
                               D_PUSH = 4'd9,  D_OUT  = 4'd10, D_ECLR = 4'd11,
                               D_JC   = 4'd12, D_DROP = 4'd13, D_SCLR = 4'd14;

  // source codes
  localparam logic [SRC_W-1:0] S_R0   = 8'd0,  S_R1   = 8'd1,  S_OPA  = 8'd2,
                               S_OPB  = 8'd3,  S_SUM  = 8'd4,  S_CRY  = 8'd5,
                               S_DIFF = 8'd6,  S_BRW  = 8'd7,  S_AND  = 8'd8,
                               S_OR   = 8'd9,  S_XOR  = 8'd10, S_NOTA = 8'd11,
                               S_SHL  = 8'd12, S_SHR  = 8'd13, S_INC  = 8'd14,
                               S_DEC  = 8'd15, S_POP  = 8'd16, S_PEEK = 8'd17,
                               S_CNT  = 8'd18, S_ERR  = 8'd19, S_RETL = 8'd20,
                               S_RETH = 8'd21, S_IN   = 8'd22, S_HI   = 8'd23,
                               S_MSK0 = 8'd24, S_MSK7 = 8'd31, S_EQ   = 8'd32,
                               S_SLT  = 8'd33, S_AZ   = 8'd34, S_SWAP = 8'd35,
                               S_ROL  = 8'd36, S_ROR  = 8'd37, S_ASR  = 8'd38,
                               S_PCNT = 8'd39, S_ONES = 8'd40, S_LAST = 8'd40;

  function automatic logic add_carry(input byte_t a, input byte_t b);
    logic [DATA_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DATA_W];
  endfunction

  // result of a computing source port; zero for anything not computed here
  function automatic byte_t unit_result(input logic [SRC_W-1:0] sel,
                                        input byte_t a, input byte_t b);
    byte_t r;
    r = '0;
    if (sel >= S_MSK0 && sel <= S_MSK7) begin
      r = byte_t'(1) << (sel - S_MSK0);
    end else begin
      case (sel)
        S_SUM:  r = a + b;
        S_CRY:  r = byte_t'(add_carry(a, b));
        S_DIFF: r = a - b;
        S_BRW:  r = byte_t'(a < b);
        S_AND:  r = a & b;
        S_OR:   r = a | b;
        S_XOR:  r = a ^ b;
        S_NOTA: r = ~a;
        S_SHL:  r = {a[DATA_W-2:0], 1'b0};
        S_SHR:  r = {1'b0, a[DATA_W-1:1]};
        S_INC:  r = a + byte_t'(1);
        S_DEC:  r = a - byte_t'(1);
        S_EQ:   r = byte_t'(a == b);
        S_SLT:  r = byte_t'($signed(a) < $signed(b));
        S_AZ:   r = byte_t'(a == '0);
        S_SWAP: r = {a[HALF_W-1:0], a[DATA_W-1:HALF_W]};
        S_ROL:  r = {a[DATA_W-2:0], a[DATA_W-1]};
        S_ROR:  r = {a[0], a[DATA_W-1:1]};
        S_ASR:  r = {a[DATA_W-1], a[DATA_W-1:1]};
        S_PCNT: for (int i = 0; i < DATA_W; i++) r = r + byte_t'(a[i]);
        S_ONES: r = '1;
        default: r = '0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/tmv_decode.sv
module tmv_decode
  import tmv_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output logic               imm,
  output logic [SRC_W-1:0]   src_sel,
  output logic [DATA_W-1:0]  literal,
  output logic [NUM_DST-1:0] dst_en
);
  move_t mv;
  assign mv      = move_t'(word);
  assign imm     = mv.imm;
  assign src_sel = mv.src;
  assign literal = mv.src;

  // one enable line per destination code; codes past the used range stay dark
  for (genvar g = 0; g < NUM_DST; g++) begin : g_dst
    if (g < DST_USED) begin : g_on
      assign dst_en[g] = (mv.dst == DST_W'(g));
    end else begin : g_off
      assign dst_en[g] = 1'b0;
    end
  end
endmodule

// File: rtl/tmv_srcmux.sv
module tmv_srcmux
  import tmv_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic             imm,
  input  logic [SRC_W-1:0] sel,
  input  byte_t            literal,
  input  byte_t            r0,
  input  byte_t            r1,
  input  byte_t            opa,
  input  byte_t            opb,
  input  byte_t            stk_top,
  input  logic [CW-1:0]    stk_count,
  input  logic             stk_err,
  input  logic [PC_W-1:0]  ret_addr,
  input  byte_t            in_port,
  input  logic [PC_W-DATA_W-1:0] hi_latch,
  output byte_t            bus,
  output logic             pop_req
);
  assign pop_req = !imm && (sel == S_POP);

  always_comb begin
    if (imm) begin
      bus = literal;
    end else begin
      case (sel)
        S_R0:           bus = r0;
        S_R1:           bus = r1;
        S_OPA:          bus = opa;
        S_OPB:          bus = opb;
        S_POP, S_PEEK:  bus = stk_top;
        S_CNT:          bus = byte_t'(stk_count);
        S_ERR:          bus = byte_t'(stk_err);
        S_RETL:         bus = ret_addr[DATA_W-1:0];
        S_RETH:         bus = ret_addr[PC_W-1:DATA_W];
        S_IN:           bus = in_port;
        S_HI:           bus = hi_latch;
        default:        bus = unit_result(sel, opa, opb);
      endcase
    end
  end
endmodule

// File: rtl/tmv_fetch.sv
module tmv_fetch #(
  parameter int PW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus,
  input  logic          hi_we,
  input  logic          take,
  output logic [PW-1:0] pc,
  output logic [PW-DW-1:0] hi,
  output logic [PW-1:0] ret_addr
);
  logic [PW-1:0]    pc_q;
  logic [PW-DW-1:0] hi_q;
  logic             armed_q;

  assign pc       = pc_q;
  assign hi       = hi_q;
  assign ret_addr = pc_q + PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      hi_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      pc_q    <= take ? {hi_q, bus} : ret_addr;
      if (hi_we) hi_q <= bus;
    end
  end

  a_r7_jump_lands: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(take) |-> pc_q == {$past(hi_q), $past(bus)});
  a_r2_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(!take) |-> pc_q == $past(pc_q) + PW'(1));
  a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(!hi_we) |-> $stable(hi_q));
endmodule

// File: rtl/tmv_stack.sv
module tmv_stack #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_src,
  input  logic          push_dst,
  input  logic          drop_dst,
  input  logic          clr,
  input  logic          err_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] top,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic          err,
  output logic          fail
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] sp_q, sp_mid, sp_d;
  logic          pop_ok, push_ok, drop_ok;
  logic          err_q, armed_q;

  // source-side pop happens first, destination-side push or discard sees the result
  always_comb begin
    pop_ok  = pop_src && (sp_q != '0);
    sp_mid  = pop_ok ? sp_q - CW'(1) : sp_q;
    push_ok = push_dst && (sp_mid != FULL);
    drop_ok = drop_dst && (sp_mid != '0);
    fail    = (pop_src && !pop_ok) | (push_dst && !push_ok) | (drop_dst && !drop_ok);
    if (clr) sp_d = '0;
    else     sp_d = sp_mid + CW'(push_ok) - CW'(drop_ok);
  end

  assign top   = (sp_q != '0) ? mem[AW'(sp_q - CW'(1))] : '0;
  assign count = sp_q;
  assign err   = err_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[sp_mid[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q    <= '0;
      err_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      sp_q    <= sp_d;
      err_q   <= (err_q & ~err_clr) | fail;
    end
  end

  a_r11_sp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= FULL);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(err_q && !err_clr) |-> err_q);
  a_r11_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(push_dst && !pop_src && !clr && sp_q == FULL) |-> sp_q == FULL && err_q);
  a_r10_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(push_dst && !pop_src && !clr && sp_q != FULL) |-> sp_q == $past(sp_q) + CW'(1));
endmodule

// File: rtl/tmove_core.sv
module tmove_core
  import tmv_pkg::*;
#(
  parameter int STK_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] instr_addr,
  input  logic [12:0] instr_word,
  input  logic [7:0]  in_port,
  output logic [7:0]  out_port,
  output logic        out_strobe,
  output logic        stack_err
);
  localparam int CW = $clog2(STK_DEPTH + 1);

  logic               imm;
  logic [SRC_W-1:0]   src_sel;
  byte_t              literal;
  logic [NUM_DST-1:0] dst_en;
  byte_t              bus;
  logic               pop_req;
  logic               take;
  logic [PC_W-1:0]    pc, ret_addr;
  logic [PC_W-DATA_W-1:0] hi;
  byte_t              stk_top;
  logic [CW-1:0]      stk_count;
  logic               stk_err, stk_fail;
  byte_t              r0_q, r1_q, opa_q, opb_q, out_q;
  logic               strobe_q, armed_q;

  tmv_decode u_dec (
    .word(instr_word), .imm(imm), .src_sel(src_sel),
    .literal(literal), .dst_en(dst_en)
  );

  tmv_srcmux #(.CW(CW)) u_mux (
    .imm(imm), .sel(src_sel), .literal(literal),
    .r0(r0_q), .r1(r1_q), .opa(opa_q), .opb(opb_q),
    .stk_top(stk_top), .stk_count(stk_count), .stk_err(stk_err),
    .ret_addr(ret_addr), .in_port(in_port), .hi_latch(hi),
    .bus(bus), .pop_req(pop_req)
  );

  assign take = dst_en[D_JMP]
              | (dst_en[D_JZ]  & (r0_q == '0))
              | (dst_en[D_JNZ] & (r0_q != '0))
              | (dst_en[D_JC]  & add_carry(opa_q, opb_q));

  tmv_fetch #(.PW(PC_W), .DW(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .bus(bus), .hi_we(dst_en[D_JHI]),
    .take(take), .pc(pc), .hi(hi), .ret_addr(ret_addr)
  );

  tmv_stack #(.DEPTH(STK_DEPTH), .DW(DATA_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .pop_src(pop_req), .push_dst(dst_en[D_PUSH]),
    .drop_dst(dst_en[D_DROP]), .clr(dst_en[D_SCLR]), .err_clr(dst_en[D_ECLR]),
    .wdata(bus), .top(stk_top), .count(stk_count), .err(stk_err), .fail(stk_fail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r0_q     <= '0;
      r1_q     <= '0;
      opa_q    <= '0;
      opb_q    <= '0;
      out_q    <= '0;
      strobe_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      armed_q  <= 1'b1;
      strobe_q <= dst_en[D_OUT];
      if (dst_en[D_R0])  r0_q  <= bus;
      if (dst_en[D_R1])  r1_q  <= bus;
      if (dst_en[D_OPA]) opa_q <= bus;
      if (dst_en[D_OPB]) opb_q <= bus;
      if (dst_en[D_OUT]) out_q <= bus;
    end
  end

  assign instr_addr = pc;
  assign out_port   = out_q;
  assign out_strobe = strobe_q;
  assign stack_err  = stk_err;

  a_r3_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dst_en));
  a_r3_g0_holds: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(!dst_en[D_R0]) |-> $stable(r0_q));
  a_r6_zero_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm && src_sel > S_LAST) |-> bus == '0);
  a_r12_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(dst_en[D_OUT]) |-> out_strobe && out_port == $past(bus));
  a_r12_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(!dst_en[D_OUT]) |-> !out_strobe && $stable(out_port));
  a_r8_jz_falls: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(dst_en[D_JZ] && r0_q != '0) |-> instr_addr == $past(instr_addr) + 16'd1);
  a_r11_fail_flags: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(stk_fail) |-> stack_err);
endmodule

// File: tb/tmove_core_tb_top.sv
module tmove_core_tb_top;
  localparam int DEPTH = 8;
  localparam int RUN   = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_addr;
  logic [12:0] instr_word;
  logic [7:0]  in_port = 8'h00;
  logic [7:0]  out_port;
  logic        out_strobe, stack_err;

  logic [12:0] rom [256];
  string       tags [256];
  int          expv [256];
  bit          seen [256];
  int          wp;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  // reference model state
  int m_pc, m_r0, m_r1, m_a, m_b, m_hi, m_out, m_strb, m_err, last;
  int m_stk[$];

  always #10 clk = ~clk;
  assign instr_word = rom[instr_addr[7:0]];

  tmove_core #(.STK_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_addr(instr_addr), .instr_word(instr_word),
    .in_port(in_port), .out_port(out_port), .out_strobe(out_strobe), .stack_err(stack_err)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic emit(int imm, int dst, int src, string tag, int exp = -1);
    rom[wp]  = 13'((src << 5) + (dst << 1) + imm);
    tags[wp] = tag;
    expv[wp] = exp;
    wp++;
  endtask

  function automatic int m_alu(int s);
    int sa, sb, n;
    sa = (m_a > 127) ? m_a - 256 : m_a;
    sb = (m_b > 127) ? m_b - 256 : m_b;
    if (s >= 24 && s <= 31) return 1 << (s - 24);
    case (s)
      4:  return (m_a + m_b) % 256;
      5:  return (m_a + m_b > 255) ? 1 : 0;
      6:  return (m_a - m_b + 256) % 256;
      7:  return (m_a < m_b) ? 1 : 0;
      8:  return m_a & m_b;
      9:  return m_a | m_b;
      10: return m_a ^ m_b;
      11: return 255 - m_a;
      12: return (m_a * 2) % 256;
      13: return m_a / 2;
      14: return (m_a + 1) % 256;
      15: return (m_a + 255) % 256;
      32: return (m_a == m_b) ? 1 : 0;
      33: return (sa < sb) ? 1 : 0;
      34: return (m_a == 0) ? 1 : 0;
      35: return (m_a % 16) * 16 + m_a / 16;
      36: return (m_a * 2) % 256 + m_a / 128;
      37: return m_a / 2 + (m_a % 2) * 128;
      38: return m_a / 2 + ((m_a >= 128) ? 128 : 0);
      39: begin
        n = 0;
        for (int v = m_a; v > 0; v = v / 2) n += v % 2;
        return n;
      end
      40: return 255;
      default: return 0;
    endcase
  endfunction

  task automatic m_step();
    int w, imm, dst, src, bus, npc, fail, tgt;
    last = m_pc % 256;
    w    = int'(rom[last]);
    imm  = w % 2;
    dst  = (w / 2) % 16;
    src  = (w / 32) % 256;
    fail = 0;
    if (imm == 1) bus = src;
    else begin
      case (src)
        0:  bus = m_r0;
        1:  bus = m_r1;
        2:  bus = m_a;
        3:  bus = m_b;
        16: if (m_stk.size() > 0) bus = m_stk.pop_back();
            else begin bus = 0; fail = 1; end
        17: bus = (m_stk.size() > 0) ? m_stk[$] : 0;
        18: bus = m_stk.size();
        19: bus = m_err;
        20: bus = (m_pc + 1) % 256;
        21: bus = ((m_pc + 1) % 65536) / 256;
        22: bus = int'(in_port);
        23: bus = m_hi;
        default: bus = m_alu(src);
      endcase
    end
    npc = (m_pc + 1) % 65536;
    tgt = m_hi * 256 + bus;
    case (dst)
      1:  m_r0 = bus;
      2:  m_r1 = bus;
      3:  m_a = bus;
      4:  m_b = bus;
      5:  m_hi = bus;
      6:  npc = tgt;
      7:  if (m_r0 == 0) npc = tgt;
      8:  if (m_r0 != 0) npc = tgt;
      9:  if (m_stk.size() >= DEPTH) fail = 1; else m_stk.push_back(bus);
      10: m_out = bus;
      12: if (m_a + m_b > 255) npc = tgt;
      13: if (m_stk.size() > 0) void'(m_stk.pop_back()); else fail = 1;
      14: m_stk.delete();
      default: ;
    endcase
    m_strb = (dst == 10) ? 1 : 0;
    m_err  = ((dst == 11) ? 0 : m_err) | fail;
    m_pc   = npc;
  endtask

  task automatic compare();
    string t;
    t = tags[last];
    check(t, "instr_addr", int'(instr_addr), m_pc);
    check(t, "out_port", int'(out_port), m_out);
    check(t, "out_strobe", int'(out_strobe), m_strb);
    check(t, "stack_err", int'(stack_err), m_err);
    if (!seen[last] && expv[last] >= 0)
      check(t, "out_port_fixed", int'(out_port), expv[last]);
    seen[last] = 1'b1;
  endtask

  task automatic build();
    int t;
    wp = 0;
    emit(1, 1, 8'h3C, "R1");
    emit(0, 10, 0, "R3", 8'h3C);
    emit(1, 2, 8'hA5, "R3");
    emit(0, 10, 1, "R12", 8'hA5);
    emit(1, 3, 8'hF0, "R1");
    emit(1, 4, 8'h25, "R1");
    emit(0, 10, 4, "R4", 8'h15);          // F0+25 modulo 256
    emit(0, 10, 5, "R4", 1);              // carry out
    for (int s = 6; s <= 15; s++) emit(0, 10, s, (s == 6 || s == 7 || s >= 14) ? "R4" : "R5");
    for (int s = 24; s <= 40; s++) emit(0, 10, s, "R5");
    emit(0, 10, 41, "R6", 0);
    emit(0, 10, 128, "R6", 0);
    emit(0, 10, 255, "R6", 0);
    emit(1, 0, 8'h55, "R3");              // null sink
    emit(1, 15, 8'h66, "R3");             // unused code
    emit(0, 10, 0, "R3", 8'h3C);
    emit(0, 10, 22, "R13");
    emit(0, 10, 22, "R13");
    emit(1, 14, 0, "R10");
    for (int k = 1; k <= DEPTH; k++) emit(1, 9, k, "R10");
    emit(0, 10, 18, "R10", DEPTH);
    emit(1, 9, 99, "R11");                // overflow
    emit(0, 10, 19, "R11", 1);
    emit(0, 10, 18, "R11", DEPTH);
    emit(0, 10, 17, "R10", DEPTH);
    emit(0, 11, 0, "R11");
    emit(0, 10, 19, "R11", 0);
    for (int k = DEPTH; k >= 1; k--) emit(0, 10, 16, "R10", k);
    emit(0, 10, 16, "R11", 0);            // underflow pop
    emit(0, 10, 19, "R11", 1);
    emit(0, 11, 0, "R11");
    emit(0, 13, 0, "R11");                // discard on empty
    emit(0, 10, 19, "R11", 1);
    emit(0, 11, 0, "R11");
    emit(1, 9, 7, "R10");
    emit(0, 9, 16, "R10");                // pop and push together
    emit(0, 10, 18, "R10", 1);
    emit(0, 10, 17, "R10", 7);
    emit(1, 14, 0, "R10");
    emit(0, 10, 18, "R10", 0);
    emit(1, 5, 0, "R7");
    t = wp + 2; emit(1, 6, t, "R7");
    emit(1, 10, 8'hEE, "R7");             // skipped
    emit(0, 10, 23, "R7", 0);
    t = wp + 2; emit(1, 7, t, "R8");      // G0 nonzero: falls through
    emit(1, 10, 8'h11, "R8", 8'h11);
    t = wp + 2; emit(1, 8, t, "R8");
    emit(1, 10, 8'h22, "R8");             // skipped
    t = wp + 2; emit(1, 12, t, "R8");
    emit(1, 10, 8'h33, "R8");             // skipped
    emit(0, 10, 20, "R9", wp + 1);
    emit(0, 10, 21, "R9", 0);
    emit(0, 0, 0, "R2");
    for (int a = wp; a < 256; a++) begin
      int imm, dst, src;
      imm = ($urandom % 3 == 0) ? 1 : 0;
      dst = $urandom % 16;
      src = ($urandom % 8 == 0) ? $urandom % 256 : $urandom % 42;
      rom[a]  = 13'((src << 5) + (dst << 1) + imm);
      tags[a] = "R2";
      expv[a] = -1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      rom[a] = '0; tags[a] = "R2"; expv[a] = -1; seen[a] = 1'b0;
    end
    build();
    m_pc = 0; m_r0 = 0; m_r1 = 0; m_a = 0; m_b = 0; m_hi = 0;
    m_out = 0; m_strb = 0; m_err = 0; last = 0;
    m_stk.delete();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", "reset instr_addr", int'(instr_addr), 0);
    check("R2", "reset out_port", int'(out_port), 0);
    check("R2", "reset out_strobe", int'(out_strobe), 0);
    check("R2", "reset stack_err", int'(stack_err), 0);
    in_port = 8'($urandom);
    rst_n = 1'b1;
    m_step();
    for (int c = 0; c < RUN; c++) begin
      @(negedge clk);
      compare();
      in_port = 8'($urandom);
      m_step();
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule